// File: doc/BRIEF.md
# Random Output Word Buffer Controller

This block sits on the read side of a deterministic random bit generator. A control write asks for either a generate or a reseed. A generate makes a block of eight 32-bit words available. Software then drains that block one word per read from a read-only output port. The block keeps count of the words that remain and shows a clamped copy of that count in a status word, together with a completion flag.

In automatic mode the block starts a new generation by itself once half of the buffer has been consumed. It also keeps a budget of generations since the last reseed. When that budget runs out, the next generate first reloads the generator from the seed input. The generator here is a small 64-bit xorshift stand-in. It is loaded from `seed_in` on every reseed and steps once per word handed out.

Two conditions hold the core in reset: a separate reset register bit, and the soft-reset bit in the control word. While either is set, reads return a fixed sentinel and control writes take no action.

Top module: `rng_word_buf`

## Requirements
- R1: Status bits 11:9 hold the quantity field. It equals the remaining word count while that count is below 4 and saturates at 4 otherwise. All other status bits are 0 except bit 0.
- R2: A control write (`wr_sel`=0) with bit 5 (start) and bit 7 (generate mode) set, outside reset, makes 8 words available and sets status bit 0 (done).
- R3: A successful read returns bits 31:0 of the generator state, then advances the state by one xorshift64 step (x^=x<<13, x^=x>>7, x^=x<<17) and lowers the word count by one.
- R4: A read while in reset or with no words left returns 0x00000BAD and raises `rd_err` in the same cycle. It changes no state.
- R5: While stored control bit 9 (single generation) is 0 and stored bit 5 is 1, a read that leaves 3 or fewer words regenerates at once, so 8 words are available again.
- R6: A control write with bit 0 (soft reset) set, outside reset, clears the word count and the status word.
- R7: A control write with bit 5 set and bit 7 clear, outside reset, is a reseed. It loads the generator from `seed_in`, empties the words, sets the generation budget to GEN_LIMIT and sets done.
- R8: Each generate lowers the budget by one. A generate that finds the budget at 0 first reseeds from `seed_in`, which leaves the budget at GEN_LIMIT-1.
- R9: The core is in reset while reset-register bit 0 or stored control bit 0 is 1. In that state a control write is stored but starts no action.
- R10: The reset register (`wr_sel`=1) comes out of reset at 1. A write of bit 0 = 1 while it holds 0 clears the stored control word, the word count and the done flag.
- R11: When a write and a read arrive in the same cycle, the write is performed and the read behaves as an empty read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 selects the control word, 1 selects the reset register |
| wr_data | input | 32 | Write data |
| rd_en | input | 1 | Output word read strobe |
| rd_data | output | 32 | Word returned for the current read |
| rd_err | output | 1 | The current read failed and got the sentinel |
| status | output | 32 | Done flag in bit 0, quantity field in bits 11:9 |
| seed_in | input | 64 | Seed loaded into the generator on a reseed |

## Verification
The bench builds the block with GEN_LIMIT set to 3 rather than 2^48. With that value the budget runs out after a few generates, so the forced reseed is reached both by directed commands and inside the random traffic. The defaults of 8 words per block, a quantity cap of 4 and a refill point of 3 are kept. With these, the saturating quantity field and the half-empty automatic refill both show up on every drained block.

// File: rtl/rwb_pkg.sv
package rwb_pkg;
  localparam logic [31:0] SENTINEL = 32'h0000_0BAD;
  // control word bit positions
  localparam int CB_SOFT   = 0;
  localparam int CB_START  = 5;
  localparam int CB_GEN    = 7;
  localparam int CB_SINGLE = 9;

  function automatic logic [63:0] xs_step(input logic [63:0] x);
    logic [63:0] t;
    t = x ^ (x << 13);
    t = t ^ (t >> 7);
    t = t ^ (t << 17);
    return t;
  endfunction

  function automatic logic [2:0] clamp_qty(input int unsigned words, input int unsigned cap);
    return (words < cap) ? 3'(words) : 3'(cap);
  endfunction

  function automatic logic refill_due(input int unsigned words_before, input int unsigned at);
    return words_before <= at + 1;
  endfunction
endpackage

// File: rtl/rwb_gen.sv
module rwb_gen #(
  parameter logic [63:0] BOOT_STATE = 64'h9E37_79B9_7F4A_7C15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        load,
  input  logic [63:0] seed,
  input  logic        step,
  output logic [31:0] word
);
  import rwb_pkg::*;
  logic [63:0] state_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    state_q <= BOOT_STATE;
    else if (load) state_q <= seed;
    else if (step) state_q <= xs_step(state_q);
  end

  assign word = state_q[31:0];
endmodule

// File: rtl/rwb_ledger.sv
module rwb_ledger #(
  parameter int unsigned BLOCK_WORDS = 8,
  parameter logic [63:0] GEN_LIMIT   = 64'd1 << 48,
  parameter int unsigned WCNT_W      = 4,
  parameter int unsigned BUD_W       = 49
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              clr,
  input  logic              gen,
  input  logic              reseed,
  input  logic              take,
  output logic [WCNT_W-1:0] words,
  output logic              budget_zero
);
  localparam logic [BUD_W-1:0]  LIM   = BUD_W'(GEN_LIMIT);
  localparam logic [WCNT_W-1:0] FULLW = WCNT_W'(BLOCK_WORDS);
  logic [BUD_W-1:0] budget_q;

  assign budget_zero = (budget_q == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      words <= '0;
    end else if (clr) begin
      words <= '0;
    end else if (gen) begin
      words <= FULLW;
    end else if (reseed) begin
      words <= '0;
    end else if (take) begin
      words <= words - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      budget_q <= '0;
    end else if (reseed) begin
      budget_q <= LIM;
    end else if (gen) begin
      budget_q <= budget_zero ? LIM - 1'b1 : budget_q - 1'b1;
    end
  end
endmodule

// File: rtl/rng_word_buf.sv
module rng_word_buf
  import rwb_pkg::*;
#(
  parameter int unsigned BLOCK_WORDS = 8,
  parameter int unsigned QTY_CAP     = 4,
  parameter int unsigned REFILL_AT   = 3,
  parameter logic [63:0] GEN_LIMIT   = 64'd1 << 48,
  parameter logic [63:0] BOOT_STATE  = 64'h9E37_79B9_7F4A_7C15
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_sel,
  input  logic [31:0] wr_data,
  input  logic        rd_en,
  output logic [31:0] rd_data,
  output logic        rd_err,
  output logic [31:0] status,
  input  logic [63:0] seed_in
);
  localparam int unsigned WCNT_W = $clog2(BLOCK_WORDS + 1);
  localparam int unsigned BUD_W  = $clog2(GEN_LIMIT + 64'd1);

  logic [11:0] ctrl_q;
  logic        rst_bit_q;
  logic        done_q;
  logic [WCNT_W-1:0] words;
  logic        budget_zero;
  logic [31:0] gen_word;

  // named events
  logic in_reset, wr_ctrl, wr_rstreg, act;
  logic do_soft, start_cmd, cmd_gen, cmd_reseed, do_full;
  logic rd_ok, auto_regen, do_gen, forced_reseed, load_seed;
  logic unused_bits;

  assign in_reset   = rst_bit_q | ctrl_q[CB_SOFT];
  assign wr_ctrl    = wr_en & ~wr_sel;
  assign wr_rstreg  = wr_en & wr_sel;
  assign act        = wr_ctrl & ~in_reset;
  assign do_soft    = act & wr_data[CB_SOFT];
  assign start_cmd  = act & ~wr_data[CB_SOFT] & wr_data[CB_START];
  assign cmd_gen    = start_cmd & wr_data[CB_GEN];
  assign cmd_reseed = start_cmd & ~wr_data[CB_GEN];
  assign do_full    = wr_rstreg & wr_data[0] & ~rst_bit_q;

  assign rd_ok      = rd_en & ~wr_en & ~in_reset & (words != '0);
  assign auto_regen = rd_ok & ~ctrl_q[CB_SINGLE] & ctrl_q[CB_START]
                    & refill_due(int'(words), REFILL_AT);
  assign do_gen        = cmd_gen | auto_regen;
  assign forced_reseed = do_gen & budget_zero;
  assign load_seed     = cmd_reseed | forced_reseed;

  assign unused_bits = ^wr_data[31:12];

  rwb_ledger #(
    .BLOCK_WORDS(BLOCK_WORDS), .GEN_LIMIT(GEN_LIMIT),
    .WCNT_W(WCNT_W), .BUD_W(BUD_W)
  ) u_ledger (
    .clk(clk), .rst_n(rst_n), .clr(do_full | do_soft), .gen(do_gen),
    .reseed(cmd_reseed), .take(rd_ok), .words(words), .budget_zero(budget_zero)
  );

  rwb_gen #(.BOOT_STATE(BOOT_STATE)) u_gen (
    .clk(clk), .rst_n(rst_n), .load(load_seed), .seed(seed_in),
    .step(rd_ok), .word(gen_word)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q    <= '0;
      rst_bit_q <= 1'b1;
      done_q    <= 1'b0;
    end else begin
      if (do_full) ctrl_q <= '0;
      else if (wr_ctrl) ctrl_q <= wr_data[11:0];
      if (wr_rstreg) rst_bit_q <= wr_data[0];
      if (do_full | do_soft) done_q <= 1'b0;
      else if (start_cmd) done_q <= 1'b1;
    end
  end

  assign rd_data = rd_ok ? gen_word : SENTINEL;
  assign rd_err  = rd_en & ~rd_ok;
  assign status  = {20'd0, clamp_qty(int'(words), QTY_CAP), 8'd0, done_q};
endmodule

// File: rtl/rwb_checker.sv
module rwb_checker (
  input logic        clk,
  input logic        rst_n,
  input logic [31:0] status,
  input logic        rd_err,
  input logic        wr_en,
  input logic        do_gen,
  input logic        do_soft,
  input logic        start_cmd,
  input logic        in_reset,
  input logic        wr_ctrl,
  input logic        forced_reseed
);
  AST_QTY_CAP: assert property (@(posedge clk) disable iff (!rst_n)
    status[11:9] <= 3'd4); // R1
  AST_GEN_FULL: assert property (@(posedge clk) disable iff (!rst_n)
    do_gen |=> status[11:9] == 3'd4); // R2
  AST_EMPTY_READ_STILL: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_err && !wr_en) |=> $stable(status)); // R4
  AST_SOFT_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    do_soft |=> status == 32'd0); // R6
  AST_DONE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    start_cmd |=> status[0]); // R7
  AST_FORCED_FILL: assert property (@(posedge clk) disable iff (!rst_n)
    forced_reseed |=> status[11:9] == 3'd4); // R8
  AST_RESET_IGNORE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_reset && wr_ctrl) |=> $stable(status)); // R9
endmodule

bind rng_word_buf rwb_checker u_chk (
  .clk(clk), .rst_n(rst_n), .status(status), .rd_err(rd_err),
  .wr_en(wr_en), .do_gen(do_gen), .do_soft(do_soft), .start_cmd(start_cmd),
  .in_reset(in_reset), .wr_ctrl(wr_ctrl), .forced_reseed(forced_reseed)
);

// File: tb/sim_rng_word_buf.sv
module sim_rng_word_buf;
  localparam logic [63:0] LIM  = 64'd3;
  localparam logic [63:0] BOOT = 64'h0123_4567_89AB_CDEF;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_sel = 1'b0, rd_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [63:0] seed_in = 64'h1111_2222_3333_4444;
  logic [31:0] rd_data, status;
  logic        rd_err;

  int n_chk = 0, n_bad = 0;

  // bench model
  logic [63:0] m_state = BOOT;
  int          m_words = 0;
  logic [63:0] m_left = 0;
  logic        m_done = 0, m_rst = 1;
  logic [11:0] m_ctrl = '0;

  always #4 clk = ~clk;

  rng_word_buf #(.GEN_LIMIT(LIM), .BOOT_STATE(BOOT)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
    .rd_en(rd_en), .rd_data(rd_data), .rd_err(rd_err), .status(status), .seed_in(seed_in)
  );

  function automatic logic [63:0] shuffle(input logic [63:0] v);
    logic [63:0] a;
    a = v ^ {v[50:0], 13'd0};
    a = a ^ {7'd0, a[63:7]};
    return a ^ {a[46:0], 17'd0};
  endfunction

  function automatic logic [31:0] exp_status();
    logic [2:0] q;
    q = (m_words > 4) ? 3'd4 : 3'(m_words);
    return {20'd0, q, 8'd0, m_done};
  endfunction

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: got %08h expected %08h", tag, act, exp);
    end
  endtask

  task automatic m_fill();
    if (m_left == 0) begin m_state = seed_in; m_left = LIM - 1; end
    else m_left = m_left - 1;
    m_words = 8;
  endtask

  task automatic op(input logic we, input logic sel, input logic [31:0] d,
                    input logic re, input string tag);
    logic inr, ok;
    logic [31:0] ed;
    string rt;
    inr = m_rst | m_ctrl[0];
    ok  = re && !we && !inr && m_words > 0;
    ed  = ok ? m_state[31:0] : 32'h0000_0BAD;
    @(negedge clk);
    wr_en = we; wr_sel = sel; wr_data = d; rd_en = re;
    #1;
    if (re) begin
      rt = (tag != "") ? tag : (ok ? "R3" : "R4");
      check(rt, rd_data, ed);
      check(rt, {31'd0, rd_err}, {31'd0, !ok});
    end
    // model update
    if (ok) begin
      m_state = shuffle(m_state);
      m_words--;
      if (!m_ctrl[9] && m_ctrl[5] && m_words <= 3) m_fill();
    end
    if (we && sel) begin
      if (d[0] && !m_rst) begin m_ctrl = '0; m_words = 0; m_done = 0; end
      m_rst = d[0];
    end
    if (we && !sel) begin
      if (!inr) begin
        if (d[0]) begin m_words = 0; m_done = 0; end
        else if (d[5]) begin
          if (d[7]) m_fill();
          else begin m_state = seed_in; m_words = 0; m_left = LIM; end
          m_done = 1;
        end
      end
      m_ctrl = d[11:0];
    end
    @(posedge clk);
    #1;
    wr_en = 0; rd_en = 0;
    check((tag != "") ? tag : "R1", status, exp_status());
  endtask

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    check("R10", status, 32'd0);                       // reset state
    op(0, 0, 0, 1, "R4");                              // read while in reset
    op(1, 0, 32'h0000_00A0, 0, "R9");                  // generate ignored in reset
    op(1, 0, 32'h0000_0000, 0, "R9");
    op(1, 1, 32'h0, 0, "R10");                         // leave reset
    op(1, 0, 32'h0000_0020, 0, "R7");                  // reseed
    op(0, 0, 0, 1, "R4");                              // empty read
    op(1, 0, 32'h0000_02A0, 0, "R2");                  // single generate
    for (int i = 0; i < 8; i++) op(0, 0, 0, 1, "");    // drain, R1/R3
    op(0, 0, 0, 1, "R4");
    seed_in = 64'hDEAD_BEEF_0BAD_F00D;
    op(1, 0, 32'h0000_02A0, 0, "R8");
    op(1, 0, 32'h0000_02A0, 0, "R8");
    op(1, 0, 32'h0000_02A0, 0, "R8");                  // budget empty: forced reseed
    op(0, 0, 0, 1, "R8");                              // first word from new seed
    op(1, 0, 32'h0000_00A0, 0, "R2");                  // auto mode
    for (int i = 0; i < 6; i++) op(0, 0, 0, 1, "R5");
    op(1, 0, 32'h0, 1, "R11");                         // write wins over read
    op(1, 0, 32'h0000_0001, 0, "R6");                  // soft reset
    op(0, 0, 0, 1, "R4");
    op(1, 0, 32'h0000_0000, 0, "R9");
    op(1, 0, 32'h0000_02A0, 0, "R2");
    op(1, 1, 32'h1, 0, "R10");                         // full reset
    op(1, 1, 32'h0, 0, "R10");
    op(0, 0, 0, 1, "R10");
    for (int i = 0; i < 4000; i++) begin
      int k;
      logic [31:0] d;
      k = $urandom_range(0, 99);
      if ($urandom_range(0, 15) == 0) seed_in = {$urandom(), $urandom() | 32'h1};
      if (k < 55) op(0, 0, 0, 1, "");
      else if (k < 80) begin
        d = 32'h20 | ($urandom_range(0, 1) << 7) | ($urandom_range(0, 1) << 9);
        op(1, 0, d, 0, "");
      end else if (k < 86) op(1, 0, 32'h1, 0, "R6");
      else if (k < 92) op(1, 0, 32'h0, $urandom_range(0, 1), "");
      else if (k < 96) op(1, 1, {31'd0, 1'($urandom_range(0, 1))}, 0, "R10");
      else op(1, 1, 32'h0, 0, "");
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule